// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A single-port synchronous SRAM in which every command (address, control and byte-lane selects) is captured on a clock edge. Its data transfer occupies the clock cycle that follows. Reads and writes share this fixed one-cycle spacing, so the data bus can alternate between the two directions on consecutive cycles with no idle cycle between them. Read data is flow-through: it comes straight from the storage array during the data cycle and passes through no output register.

The array is a behavioural register model of `2**ADDR_W` words. Each 36-bit word is split into four 9-bit lanes. A command either loads a new address or advances an internal 4-word burst counter. The burst order is linear or interleaved, chosen by a static input. A `hold` input freezes the whole block. Three chip selects allow depth expansion. An asynchronous drive enable can silence the read bus at any time. The data bus is presented as separate write-data, read-data and read-drive-enable ports.

The control is a three-state machine on the data phase: `PH_IDLE` (no transfer), `PH_READ` (array word driven out) and `PH_WRITE` (write data taken at the next edge). On an edge with `hold` low, the transitions are as follows:
- load-read goes to `PH_READ` from any state.
- load-write goes to `PH_WRITE` from any state.
- deselect goes to `PH_IDLE` from any state.
- advance keeps `PH_READ` or `PH_WRITE` and steps the burst.
- advance in `PH_IDLE` stays in `PH_IDLE`.

An edge with `hold` high keeps the state.

Top module: `zbt_sram`

## Requirements
- R1: A read command is captured at edge k. During the cycle after edge k, `rdata` carries the word at the command's address and `rdata_oe` is 1. A write command is captured at edge k. Its `wdata` is written at edge k+1.
- R2: Read and write commands may be issued on consecutive cycles in any mix with no idle cycle. A read that directly follows a write to the same address returns the newly written data.
- R3: While `hold`=1, every synchronous input is ignored at the edge. The burst position, the pending transfer and the array all keep their values. A pending write is deferred to the next edge with `hold`=0.
- R4: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. The selects are sampled only when `advance`=0. A load cycle that is not selected starts nothing and ends any burst. A transfer pending from the previous command still completes at that edge.
- R5: `rdata_oe` is 0 in the cycle after a deselect command or a write command.
- R6: `drv_en_n`=1 forces `rdata_oe` to 0 at once, regardless of pipeline state. `rdata` is 0 whenever `rdata_oe` is 0.
- R7: `lane_wr_n[i]`=0 enables lane i, which is bits 9i+8 down to 9i. The lane selects are sampled together with the load or advance command that a write belongs to. Lanes with a select of 1 keep their stored contents.
- R8: With `advance`=1, an active burst continues with the same read/write type. Only the two low address bits change. The k-th word (k=0..3) uses `base+k` modulo 4 when `seq_linear`=1, or `base XOR k` when `seq_linear`=0. The counter wraps after the fourth word.
- R9: An advance cycle when no burst is active (after reset or a deselect) performs no transfer, and `rdata_oe` stays 0.
- R10: Synchronous active-low reset `rst_n` returns the block to `PH_IDLE`, so `rdata_oe` is 0 in the cycle after a reset edge. The array contents are not reset.
- R11: In a load cycle, `rd_nwr`=1 selects a read and `rd_nwr`=0 selects a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| hold | input | 1 | 1 stalls the block: the edge is ignored |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| advance | input | 1 | 0 loads a new address, 1 steps the burst |
| rd_nwr | input | 1 | Command type on load: 1 read, 0 write |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address for load commands |
| drv_en_n | input | 1 | Asynchronous read-drive enable, active low |
| wdata | input | 36 | Write data, taken in the data cycle |
| rdata | output | 36 | Flow-through read data |
| rdata_oe | output | 1 | 1 while `rdata` is being driven |

## Verification
The hardest situation to reach is a pending data phase that meets a disturbance in its own data cycle. Examples are a write whose data edge is held off by `hold`, a deselect that arrives while a write burst still has a transfer owed, and an advance that lands after the burst was cut off. Directed sequences build each of these explicitly, starting bursts at every low-address offset in both orders and running past the wrap. A long weighted-random phase then mixes stalls, select drops, lane masks and drive-enable pulses on top of a fully initialised array. A behavioural model checks every cycle against the ports.

// File: rtl/zsram_pkg.sv
package zsram_pkg;

    localparam int LANE_W    = 9;
    localparam int LANES     = 4;
    localparam int WORD_W    = LANE_W * LANES;
    localparam int BURST_LEN = 4;

    // Data-phase state of the one-cycle command pipeline
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

endpackage

// File: rtl/zsram_fsm.sv
module zsram_fsm
    import zsram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    input  logic advance,
    input  logic rd_nwr,
    output logic load_o,
    output logic step_o,
    output logic rd_phase_o,
    output logic wr_commit_o
);

    phase_e state_q;
    phase_e state_d;
    logic   chip_sel;

    assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        step_o  = 1'b0;
        if (!hold) begin
            if (!advance) begin
                if (chip_sel) begin
                    load_o  = 1'b1;
                    state_d = rd_nwr ? PH_READ : PH_WRITE;
                end else begin
                    state_d = PH_IDLE;
                end
            end else begin
                unique case (state_q)
                    PH_IDLE: begin
                        state_d = PH_IDLE;
                    end
                    PH_READ, PH_WRITE: begin
                        step_o  = 1'b1;
                        state_d = state_q;
                    end
                    default: begin
                        state_d = PH_IDLE;
                    end
                endcase
            end
        end
    end

    // Outputs of the data phase
    always_comb begin
        rd_phase_o  = 1'b0;
        wr_commit_o = 1'b0;
        unique case (state_q)
            PH_IDLE:  ;
            PH_READ:  rd_phase_o  = 1'b1;
            PH_WRITE: wr_commit_o = !hold;
            default:  ;
        endcase
    end

endmodule

// File: rtl/zsram_burst.sv
module zsram_burst #(
    parameter int ADDR_W    = 8,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              seq_linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int CNT_W = $clog2(BURST_LEN);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  low_lin;
    logic [CNT_W-1:0]  low_ilv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign low_lin = base_q[CNT_W-1:0] + cnt_q;
    assign low_ilv = base_q[CNT_W-1:0] ^ cnt_q;

    generate
        if (ADDR_W > CNT_W) begin : g_upper
            assign addr_o = {base_q[ADDR_W-1:CNT_W], (seq_linear ? low_lin : low_ilv)};
        end else begin : g_flat
            assign addr_o = seq_linear ? low_lin : low_ilv;
        end
    endgenerate

endmodule

// File: rtl/zsram_array.sv
module zsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [LANES-1:0]          lane_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] store [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && lane_en[g]) begin
                    store[addr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            // flow-through read path
            assign rdata[g*LANE_W +: LANE_W] = store[addr];
        end
    endgenerate

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                advance,
    input  logic                rd_nwr,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic                seq_linear,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                drv_en_n,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                rdata_oe
);

    logic              load;
    logic              step;
    logic              rd_phase;
    logic              wr_commit;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  lane_q;
    logic [WORD_W-1:0] arr_rdata;

    zsram_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (hold),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .advance     (advance),
        .rd_nwr      (rd_nwr),
        .load_o      (load),
        .step_o      (step),
        .rd_phase_o  (rd_phase),
        .wr_commit_o (wr_commit)
    );

    zsram_burst #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .seq_linear (seq_linear),
        .addr_in    (addr),
        .addr_o     (cur_addr)
    );

    // lane selects travel with their command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (load || step) begin
            lane_q <= ~lane_wr_n;
        end
    end

    zsram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_commit),
        .lane_en (lane_q),
        .addr    (cur_addr),
        .wdata   (wdata),
        .rdata   (arr_rdata)
    );

    assign rdata_oe = rd_phase && !drv_en_n;
    assign rdata    = rdata_oe ? arr_rdata : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              advance,
    input logic              rd_nwr,
    input logic              drv_en_n,
    input logic [35:0]       rdata,
    input logic              rdata_oe
);

    logic selected;
    assign selected = !sel_a_n && sel_b && !sel_c_n;

    AST_READ_CMD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !advance && selected && rd_nwr) |=> (drv_en_n || rdata_oe)); // R1

    AST_STALL_HOLDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !drv_en_n) |=> (drv_en_n || $stable(rdata_oe))); // R3

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !advance && !selected) |=> !rdata_oe); // R4

    AST_WRITE_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !advance && selected && !rd_nwr) |=> !rdata_oe); // R5

    AST_DRIVE_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_n |-> !rdata_oe); // R6

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0)); // R6

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .advance  (advance),
    .rd_nwr   (rd_nwr),
    .drv_en_n (drv_en_n),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL = 3'b010;   // {sel_a_n, sel_b, sel_c_n}

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          advance = 1'b0;
    logic          rd_nwr = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          seq_linear = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          drv_en_n = 1'b0;
    logic [35:0]   wdata = '0;
    logic [35:0]   rdata;
    logic          rdata_oe;

    always #5 clk = ~clk;

    zbt_sram #(.ADDR_W(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .advance    (advance),
        .rd_nwr     (rd_nwr),
        .lane_wr_n  (lane_wr_n),
        .seq_linear (seq_linear),
        .addr       (addr),
        .drv_en_n   (drv_en_n),
        .wdata      (wdata),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "R10";

    // behavioural reference: 0 idle, 1 read, 2 write
    logic [35:0] ref_mem [DEPTH];
    int          m_ph = 0;
    int          m_base = 0;
    int          m_cnt = 0;
    logic [3:0]  m_lanes = 4'h0;

    function int m_addr();
        if (seq_linear)
            return (m_base & ~3) | ((m_base + m_cnt) % 4);
        return m_base ^ m_cnt;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
        end else if (!hold) begin
            if (m_ph == 2) begin
                for (int l = 0; l < 4; l++)
                    if (m_lanes[l]) ref_mem[m_addr()][l*9 +: 9] = wdata[l*9 +: 9];
            end
            if (!advance) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    m_base  = int'(addr);
                    m_cnt   = 0;
                    m_lanes = ~lane_wr_n;
                    m_ph    = rd_nwr ? 1 : 2;
                end else begin
                    m_ph = 0;
                end
            end else if (m_ph != 0) begin
                m_cnt   = (m_cnt + 1) % 4;
                m_lanes = ~lane_wr_n;
            end
        end
    end

    always @(negedge clk) begin
        logic exp_oe;
        exp_oe = (m_ph == 1) && !drv_en_n;
        vectors++;
        if (rdata_oe !== exp_oe) begin
            miscompares++;
            $display("FAIL %s: rdata_oe=%0b expected %0b at %0t", tag, rdata_oe, exp_oe, $time);
        end else if (exp_oe && (rdata !== ref_mem[m_addr()])) begin
            miscompares++;
            $display("FAIL %s: rdata=%h expected %h at %0t", tag, rdata, ref_mem[m_addr()], $time);
        end else if (!exp_oe && (rdata !== 36'h0)) begin
            miscompares++;
            $display("FAIL %s: rdata=%h expected 0 while undriven at %0t", tag, rdata, $time);
        end
    end

    task automatic drive(input logic h, input logic [2:0] ce, input logic adv,
                         input logic rw, input logic [3:0] ln, input int a, input logic oe);
        hold      = h;
        {sel_a_n, sel_b, sel_c_n} = ce;
        advance   = adv;
        rd_nwr    = rw;
        lane_wr_n = ln;
        addr      = AW'(a);
        drv_en_n  = oe;
        wdata     = {4'($urandom()), 32'($urandom())};
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [3:0] ln);
        drive(1'b0, SEL, 1'b0, 1'b0, ln, a, 1'b0);
    endtask

    task automatic rd(input int a);
        drive(1'b0, SEL, 1'b0, 1'b1, 4'hF, a, 1'b0);
    endtask

    task automatic adv();
        drive(1'b0, 3'b101, 1'b1, 1'b1, 4'h0, 0, 1'b0);
    endtask

    task automatic stall();
        drive(1'b1, 3'($urandom()), 1'($urandom()), 1'($urandom()), 4'($urandom()),
              int'($urandom_range(0, DEPTH-1)), 1'b0);
    endtask

    task automatic desel(input logic [2:0] ce);
        drive(1'b0, ce, 1'b0, 1'b1, 4'hF, 0, 1'b0);
    endtask

    initial begin
        #2000000;
        miscompares++;
        $display("FAIL %s: watchdog expired, actual hung expected finished", tag);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R10: reset quiets the bus
        tag = "R10";
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R9: advance with no burst after reset
        tag = "R9";
        adv(); adv();

        // R11: fill the array with load-write commands
        tag = "R11";
        for (int a = 0; a < DEPTH; a++) wr(a, 4'h0);
        desel(3'b110);

        // R1: one-cycle read latency over a run of addresses
        tag = "R1";
        for (int a = 0; a < 16; a++) rd(a * 7 % DEPTH);
        desel(3'b110);

        // R2: alternating write/read with no gap
        tag = "R2";
        for (int i = 0; i < 16; i++) begin wr(20 + i, 4'h0); rd(20 + i); end
        for (int i = 0; i < 8; i++) begin rd(30 + i); wr(30 + i, 4'h0); end
        rd(33);

        // R3: stalls during write and read data phases
        tag = "R3";
        wr(40, 4'h0); stall(); stall(); stall(); rd(40); stall(); stall(); rd(41);
        wr(42, 4'h0); adv(); stall(); adv(); stall(); rd(42); adv(); stall(); adv();

        // R4: deselect through each select cuts bursts
        tag = "R4";
        rd(64); adv(); adv(); desel(3'b110); adv(); adv();
        wr(68, 4'h0); adv(); desel(3'b000); adv(); rd(68); adv();
        rd(72); desel(3'b011); adv(); rd(73);

        // R5: drive off after write or deselect
        tag = "R5";
        rd(80); wr(80, 4'h0); rd(80); wr(81, 4'h0); desel(3'b110); rd(81);

        // R6: asynchronous drive enable
        tag = "R6";
        rd(90); drive(1'b0, SEL, 1'b1, 1'b1, 4'h0, 0, 1'b1);
        adv(); drive(1'b0, SEL, 1'b0, 1'b1, 4'hF, 91, 1'b1); adv();
        #2 drv_en_n = 1'b1; #1;
        if (rdata_oe !== 1'b0) begin
            miscompares++;
            $display("FAIL R6: rdata_oe=%0b expected 0 mid-cycle", rdata_oe);
        end
        vectors++;
        drv_en_n = 1'b0;
        @(posedge clk); #1;

        // R7: partial lane writes
        tag = "R7";
        wr(100, 4'b1110); rd(100); wr(100, 4'b0101); rd(100);
        wr(100, 4'b1111); rd(100); wr(101, 4'b0111); adv(); rd(101); rd(102);
        drive(1'b0, SEL, 1'b0, 1'b0, 4'b1011, 103, 1'b0);
        drive(1'b0, SEL, 1'b1, 1'b1, 4'b1101, 0, 1'b0);
        rd(103); rd(104);

        // R8: bursts in both orders from every offset, past the wrap
        tag = "R8";
        for (int o = 0; o < 2; o++) begin
            seq_linear = (o == 0);
            for (int b = 0; b < 4; b++) begin
                wr(120 + b + 4 * o, 4'h0);
                for (int k = 0; k < 6; k++) adv();
                rd(120 + b + 4 * o);
                for (int k = 0; k < 6; k++) adv();
            end
        end
        seq_linear = 1'b1;

        // mixed random traffic
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            logic       h;
            logic [2:0] ce;
            logic [3:0] ln;
            if (i % 97 == 0) seq_linear = ~seq_linear;
            if (i == 1500) tag = "R4";
            h  = ($urandom_range(0, 99) < 12);
            ce = ($urandom_range(0, 9) == 0) ? 3'($urandom()) : SEL;
            ln = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'h0;
            drive(h, ce, 1'($urandom()), 1'($urandom()), ln,
                  int'($urandom_range(0, DEPTH-1)), ($urandom_range(0, 9) == 0));
        end

        // R10: reset in the middle of a read burst
        tag = "R10";
        rd(5); adv();
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        adv(); adv();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule